// File: doc/BRIEF.md
# Flash command state controller

This block interprets write cycles from a microcontroller bus and turns them into commands for a flash array model. A command is recognised from a short write sequence: two unlock writes, then a command write, and for program and erase one further write that carries the target. The controller holds a mode register that moves between array read, status/ID read, programming, sector erasing, bulk erasing, error and a recovery wait. Program and erase times are stood in for by a down-counter. When an operation finishes, the controller gives the array model a one-cycle commit pulse with the operation kind, address, data and sector mask.

Each sector carries a protection bit. A program or erase aimed at a protected sector is dropped without any sign at the outputs. The bits are loaded through a configuration port that stands in for the external programming path, and they read back as two byte-wide registers. A reset command ends status reads. It is ignored while a program or bulk erase runs, it aborts a sector erase, and it clears an error. An abort or an error clear first passes through a timed recovery wait.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A command starts with data AAh written to address 555h, then data 55h written to AAAh. Both addresses are compared on bus_addr[11:0] only. A third write to 555h chooses the command: A0h means the next write programs its data at its address, 80h means the next write erases (30h erases that address's sector, 10h erases all sectors), 90h enters status/ID read, F0h is reset. A single write of F0h at any address while no sequence is under way is also reset.
- R2: A write that does not match the expected address/data pair at any step of a sequence returns the decoder to idle, and no command is executed.
- R3: A program to an unprotected sector sets mode 2 and busy for exactly PROG_CYC cycles. After that the mode returns to 0 and arr_commit_o pulses for one cycle with arr_kind_o=1, the target address, the data and a one-hot sector mask.
- R4: The sector index is bus_addr[AW-1:AW-3], where sectors 0-3 are primary and 4-5 are secondary. A program or sector erase aimed at a sector whose bit is 1, or at index 6 or 7, leaves mode 0 with no busy and no commit. A bulk erase covers only the unprotected sectors and is dropped when all of them are protected.
- R5: A reset command issued during a program or a bulk erase is ignored. The operation completes on its normal schedule.
- R6: A reset during a sector erase aborts it. The mode becomes 6 with busy high for ABORT_CYC cycles, then returns to 0, and no commit is produced.
- R7: op_fail sampled high during a program or erase sets mode 5 and drops the commit. In mode 5 only reset is accepted. It gives mode 6 for ERRCLR_CYC cycles, then mode 0.
- R8: Data 90h at the third unlock step sets mode 1. Mode 1 ignores every command except reset, which returns to mode 0 at once.
- R9: prot_pri_o carries primary sector bits 0-3 in bits 0-3 with bits 7-4 at zero. prot_sec_o carries secondary sector bits 0-1 in bits 0-1, the security flag in bit 7, and zeros elsewhere.
- R10: cfg_we loads cfg_prot (bit i belongs to sector i) and cfg_secure, and is ignored while busy_o is high. All protection bits are zero after reset.
- R11: stat_o holds busy in bit 7, the error flag (mode 5) in bit 5, the mode code in bits 2:0 and zeros elsewhere. busy_o is high exactly in modes 2, 3, 4 and 6.
- R12: A sector erase runs for SERASE_CYC cycles and commits with kind 2 and a one-hot mask. A bulk erase runs for BERASE_CYC cycles and commits with kind 3 and the mask of unprotected sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | AW | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| cfg_we | input | 1 | Load strobe for protection configuration |
| cfg_prot | input | NSEC_PRI+NSEC_SEC | New protection bits, bit i for sector i |
| cfg_secure | input | 1 | New security flag |
| op_fail | input | 1 | Failure indication from the array model |
| mode_o | output | 3 | Current mode code |
| busy_o | output | 1 | Operation or recovery in progress |
| stat_o | output | 8 | Status byte |
| prot_pri_o | output | 8 | Primary protection register |
| prot_sec_o | output | 8 | Secondary protection register |
| arr_commit_o | output | 1 | One-cycle completion pulse to the array |
| arr_kind_o | output | 2 | Completed operation: 1 program, 2 sector erase, 3 bulk |
| arr_addr_o | output | AW | Address of the completed operation |
| arr_data_o | output | 8 | Program data |
| arr_mask_o | output | NSEC_PRI+NSEC_SEC | Sectors affected |

## Verification
The assertions assume that bus_we, cfg_we and op_fail are driven synchronously and carry known values after reset. They also assume op_fail is only meaningful while an operation is busy. The bench changes every input half a cycle away from the sampling edge. It raises op_fail only inside a running program. It loads configuration mostly while idle, and once deliberately during an operation to show that the load is ignored. Random broken sequences never use AAh as the final stray write, so every trial starts with the decoder idle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_READ   = 3'd0,
    M_STAT   = 3'd1,
    M_PROG   = 3'd2,
    M_SERASE = 3'd3,
    M_BERASE = 3'd4,
    M_ERR    = 3'd5,
    M_RECOV  = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    C_NONE, C_RESET, C_STAT, C_PROG, C_SERASE, C_BULK
  } cmd_e;

  typedef enum logic [2:0] {
    D_IDLE, D_U1, D_U2, D_PGM, D_ERS
  } dec_e;

  localparam int UA_W = 12;
  localparam logic [UA_W-1:0] UNLOCK_A1 = 12'h555;
  localparam logic [UA_W-1:0] UNLOCK_A2 = 12'hAAA;
  localparam logic [7:0] UNLOCK_D1 = 8'hAA;
  localparam logic [7:0] UNLOCK_D2 = 8'h55;
  localparam logic [7:0] OPC_PROG  = 8'hA0;
  localparam logic [7:0] OPC_ERS   = 8'h80;
  localparam logic [7:0] OPC_STAT  = 8'h90;
  localparam logic [7:0] OPC_RST   = 8'hF0;
  localparam logic [7:0] OPC_SEC   = 8'h30;
  localparam logic [7:0] OPC_BULK  = 8'h10;

  localparam logic [1:0] K_PROG   = 2'd1;
  localparam logic [1:0] K_SERASE = 2'd2;
  localparam logic [1:0] K_BULK   = 2'd3;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [UA_W-1:0] wr_lo,
  input  logic [7:0]      wr_data,
  output cmd_e            cmd_o
);

  dec_e st_q, st_d;
  cmd_e cmd_d;
  logic hit1, hit2;

  assign hit1 = (wr_lo == UNLOCK_A1) && (wr_data == UNLOCK_D1);
  assign hit2 = (wr_lo == UNLOCK_A2) && (wr_data == UNLOCK_D2);

  always_comb begin
    st_d  = st_q;
    cmd_d = C_NONE;
    case (st_q)
      D_IDLE: begin
        if (wr_data == OPC_RST) cmd_d = C_RESET;
        else if (hit1)          st_d  = D_U1;
      end
      D_U1: st_d = hit2 ? D_U2 : D_IDLE;
      D_U2: begin
        st_d = D_IDLE;
        if (wr_lo == UNLOCK_A1) begin
          case (wr_data)
            OPC_PROG: st_d  = D_PGM;
            OPC_ERS:  st_d  = D_ERS;
            OPC_STAT: cmd_d = C_STAT;
            OPC_RST:  cmd_d = C_RESET;
            default:  ;
          endcase
        end
      end
      D_PGM: begin
        st_d  = D_IDLE;
        cmd_d = C_PROG;
      end
      D_ERS: begin
        st_d = D_IDLE;
        if (wr_data == OPC_SEC)       cmd_d = C_SERASE;
        else if (wr_data == OPC_BULK) cmd_d = C_BULK;
      end
      default: st_d = D_IDLE;
    endcase
    if (!wr_en) begin
      st_d  = st_q;
      cmd_d = C_NONE;
    end
  end

  assign cmd_o = cmd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= D_IDLE;
    else if (wr_en) st_q <= st_d;
  end

endmodule

// File: rtl/flash_cmd_prot.sv
module flash_cmd_prot #(
  parameter int NSEC_PRI = 4,
  parameter int NSEC_SEC = 2,
  parameter int SB       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic                         cfg_lock,
  input  logic [NSEC_PRI+NSEC_SEC-1:0] cfg_prot,
  input  logic                         cfg_secure,
  input  logic [SB-1:0]                look_sec,
  output logic                         look_prot,
  output logic [NSEC_PRI+NSEC_SEC-1:0] unprot_mask,
  output logic [7:0]                   pri_o,
  output logic [7:0]                   sec_o
);

  localparam int NSEC = NSEC_PRI + NSEC_SEC;

  logic [NSEC-1:0] prot_q;
  logic            secure_q;
  logic            load_en;

  assign load_en = cfg_we && !cfg_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q   <= '0;
      secure_q <= 1'b0;
    end else if (load_en) begin
      prot_q   <= cfg_prot;
      secure_q <= cfg_secure;
    end
  end

  // Indices with no sector behind them count as protected.
  always_comb begin
    look_prot = 1'b1;
    for (int i = 0; i < NSEC; i++) begin
      if (look_sec == SB'(i)) look_prot = prot_q[i];
    end
  end

  assign unprot_mask = ~prot_q;

  for (genvar g = 0; g < 8; g++) begin : g_pri
    if (g < NSEC_PRI) begin : g_on
      assign pri_o[g] = prot_q[g];
    end else begin : g_off
      assign pri_o[g] = 1'b0;
    end
  end

  for (genvar g = 0; g < 7; g++) begin : g_sec
    if (g < NSEC_SEC) begin : g_on
      assign sec_o[g] = prot_q[NSEC_PRI+g];
    end else begin : g_off
      assign sec_o[g] = 1'b0;
    end
  end
  assign sec_o[7] = secure_q;

endmodule

// File: rtl/flash_cmd_tmr.sv
module flash_cmd_tmr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign zero_o = (cnt_q == '0);
  assign cnt_en = load || !zero_o;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW         = 15,
  parameter int SEC_BITS   = 3,
  parameter int NSEC_PRI   = 4,
  parameter int NSEC_SEC   = 2,
  parameter int PROG_CYC   = 8,
  parameter int SERASE_CYC = 40,
  parameter int BERASE_CYC = 60,
  parameter int ABORT_CYC  = 12,
  parameter int ERRCLR_CYC = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_we,
  input  logic [AW-1:0]                bus_addr,
  input  logic [7:0]                   bus_wdata,
  input  logic                         cfg_we,
  input  logic [NSEC_PRI+NSEC_SEC-1:0] cfg_prot,
  input  logic                         cfg_secure,
  input  logic                         op_fail,
  output logic [2:0]                   mode_o,
  output logic                         busy_o,
  output logic [7:0]                   stat_o,
  output logic [7:0]                   prot_pri_o,
  output logic [7:0]                   prot_sec_o,
  output logic                         arr_commit_o,
  output logic [1:0]                   arr_kind_o,
  output logic [AW-1:0]                arr_addr_o,
  output logic [7:0]                   arr_data_o,
  output logic [NSEC_PRI+NSEC_SEC-1:0] arr_mask_o
);

  localparam int NSEC = NSEC_PRI + NSEC_SEC;
  localparam int MAXC = imax(imax(imax(PROG_CYC, SERASE_CYC), imax(BERASE_CYC, ABORT_CYC)), ERRCLR_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  cmd_e            cmd;
  mode_e           mode_q, mode_d;
  logic [SEC_BITS-1:0] sec_idx;
  logic            sec_prot;
  logic [NSEC-1:0] unprot_mask, sec_onehot;
  logic            tmr_load, tmr_zero;
  logic [CW-1:0]   tmr_val;
  logic            op_ld, commit_d, commit_q, busy, is_reset;
  logic [1:0]      kind_d, kind_q;
  logic [NSEC-1:0] mask_d, mask_q;
  logic [AW-1:0]   addr_q;
  logic [7:0]      data_q;

  flash_cmd_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we),
    .wr_lo   (bus_addr[UA_W-1:0]),
    .wr_data (bus_wdata),
    .cmd_o   (cmd)
  );

  assign sec_idx = bus_addr[AW-1 -: SEC_BITS];

  flash_cmd_prot #(
    .NSEC_PRI (NSEC_PRI),
    .NSEC_SEC (NSEC_SEC),
    .SB       (SEC_BITS)
  ) u_prot (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_lock    (busy),
    .cfg_prot    (cfg_prot),
    .cfg_secure  (cfg_secure),
    .look_sec    (sec_idx),
    .look_prot   (sec_prot),
    .unprot_mask (unprot_mask),
    .pri_o       (prot_pri_o),
    .sec_o       (prot_sec_o)
  );

  flash_cmd_tmr #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero_o   (tmr_zero)
  );

  assign sec_onehot = NSEC'(1) << sec_idx;
  assign is_reset   = (cmd == C_RESET);

  always_comb begin
    mode_d   = mode_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    op_ld    = 1'b0;
    kind_d   = kind_q;
    mask_d   = mask_q;
    commit_d = 1'b0;
    case (mode_q)
      M_READ: begin
        case (cmd)
          C_STAT: mode_d = M_STAT;
          C_PROG: if (!sec_prot) begin
            mode_d = M_PROG;   tmr_load = 1'b1; tmr_val = CW'(PROG_CYC - 1);
            op_ld  = 1'b1;     kind_d   = K_PROG; mask_d = sec_onehot;
          end
          C_SERASE: if (!sec_prot) begin
            mode_d = M_SERASE; tmr_load = 1'b1; tmr_val = CW'(SERASE_CYC - 1);
            op_ld  = 1'b1;     kind_d   = K_SERASE; mask_d = sec_onehot;
          end
          C_BULK: if (|unprot_mask) begin
            mode_d = M_BERASE; tmr_load = 1'b1; tmr_val = CW'(BERASE_CYC - 1);
            op_ld  = 1'b1;     kind_d   = K_BULK; mask_d = unprot_mask;
          end
          default: ;
        endcase
      end
      M_STAT: if (is_reset) mode_d = M_READ;
      M_PROG, M_BERASE: begin
        if (op_fail) mode_d = M_ERR;
        else if (tmr_zero) begin
          mode_d   = M_READ;
          commit_d = 1'b1;
        end
      end
      M_SERASE: begin
        if (op_fail) mode_d = M_ERR;
        else if (is_reset) begin
          mode_d = M_RECOV; tmr_load = 1'b1; tmr_val = CW'(ABORT_CYC - 1);
        end else if (tmr_zero) begin
          mode_d   = M_READ;
          commit_d = 1'b1;
        end
      end
      M_ERR: if (is_reset) begin
        mode_d = M_RECOV; tmr_load = 1'b1; tmr_val = CW'(ERRCLR_CYC - 1);
      end
      M_RECOV: if (tmr_zero) mode_d = M_READ;
      default: mode_d = M_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_READ;
      commit_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      commit_q <= commit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      mask_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (op_ld) begin
      kind_q <= kind_d;
      mask_q <= mask_d;
      addr_q <= bus_addr;
      data_q <= bus_wdata;
    end
  end

  assign busy = (mode_q == M_PROG) || (mode_q == M_SERASE) ||
                (mode_q == M_BERASE) || (mode_q == M_RECOV);

  assign mode_o       = mode_q;
  assign busy_o       = busy;
  assign stat_o       = {busy, 1'b0, (mode_q == M_ERR), 2'b00, mode_q};
  assign arr_commit_o = commit_q;
  assign arr_kind_o   = kind_q;
  assign arr_addr_o   = addr_q;
  assign arr_data_o   = data_q;
  assign arr_mask_o   = mask_q;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_o,
  input logic       busy_o,
  input logic       arr_commit_o,
  input logic [7:0] prot_pri_o,
  input logic [7:0] prot_sec_o
);

  assert_commit_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_commit_o |=> !arr_commit_o);

  assert_commit_after_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    arr_commit_o |-> ($past(busy_o) && mode_o == 3'd0));

  // R5: a running program or bulk erase only ends by completion or failure
  assert_reset_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 || mode_o == 3'd4) |=>
      (mode_o == $past(mode_o) || mode_o == 3'd0 || mode_o == 3'd5));

  assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd6) |-> !arr_commit_o);

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5) |=> (mode_o == 3'd5 || mode_o == 3'd6));

  assert_stat_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1) |=> (mode_o == 3'd1 || mode_o == 3'd0));

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(prot_pri_o) && $stable(prot_sec_o)));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_o       (mode_o),
  .busy_o       (busy_o),
  .arr_commit_o (arr_commit_o),
  .prot_pri_o   (prot_pri_o),
  .prot_sec_o   (prot_sec_o)
);

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;

  localparam int AW = 15;
  localparam int PC = 8;
  localparam int SC = 40;
  localparam int BC = 60;
  localparam int AC = 12;
  localparam int EC = 20;

  logic          clk, rst_n;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic          cfg_we;
  logic [5:0]    cfg_prot;
  logic          cfg_secure;
  logic          op_fail;
  logic [2:0]    mode_o;
  logic          busy_o;
  logic [7:0]    stat_o, prot_pri_o, prot_sec_o;
  logic          arr_commit_o;
  logic [1:0]    arr_kind_o;
  logic [AW-1:0] arr_addr_o;
  logic [7:0]    arr_data_o;
  logic [5:0]    arr_mask_o;

  flash_cmd_ctrl #(
    .AW(AW), .SEC_BITS(3), .NSEC_PRI(4), .NSEC_SEC(2),
    .PROG_CYC(PC), .SERASE_CYC(SC), .BERASE_CYC(BC),
    .ABORT_CYC(AC), .ERRCLR_CYC(EC)
  ) u_dut (.*);

  int tot, bad, ncommit;
  logic [5:0] eprot;
  logic       esec;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (arr_commit_o === 1'b1) ncommit++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string msg);
    tot++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  function automatic logic is_prot(input logic [AW-1:0] a);
    int s = int'(a[AW-1 -: 3]);
    return (s >= 6) ? 1'b1 : eprot[s];
  endfunction

  function automatic logic [7:0] exp_pri();
    return {4'h0, eprot[3:0]};
  endfunction

  function automatic logic [7:0] exp_sec();
    return {esec, 5'h00, eprot[5:4]};
  endfunction

  function automatic logic [5:0] onehot(input logic [AW-1:0] a);
    return 6'(1) << a[AW-1 -: 3];
  endfunction

  // Called at a falling edge; the write is taken at the next rising edge.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic unlock();
    wr(15'h0555, 8'hAA);
    wr(15'h0AAA, 8'h55);
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); wr(15'h0555, 8'hA0); wr(a, d);
  endtask

  task automatic do_erase(input logic [AW-1:0] a, input logic [7:0] op);
    unlock(); wr(15'h0555, 8'h80); wr(a, op);
  endtask

  task automatic cfg(input logic [5:0] p, input logic s, input logic expect_load);
    cfg_we = 1'b1; cfg_prot = p; cfg_secure = s;
    @(negedge clk);
    cfg_we = 1'b0;
    if (expect_load) begin eprot = p; esec = s; end
  endtask

  task automatic expect_op(input logic [1:0] kind, input int cyc, input int done_edges,
                           input logic [AW-1:0] a, input logic [7:0] d,
                           input logic [5:0] m, input string rq);
    int c0;
    c0 = ncommit;
    chk(busy_o, 1, {rq, " busy at start"});
    repeat (cyc - 1 - done_edges) @(negedge clk);
    chk(busy_o, 1, {rq, " busy on last cycle"});
    @(negedge clk);
    chk(mode_o, 0, {rq, " mode after op"});
    chk(arr_commit_o, 1, {rq, " commit pulse"});
    chk(arr_kind_o, kind, {rq, " kind"});
    chk(arr_addr_o, a, {rq, " addr"});
    if (kind == 2'd1) chk(arr_data_o, d, {rq, " data"});
    chk(arr_mask_o, m, {rq, " mask"});
    @(negedge clk);
    chk(ncommit, c0 + 1, {rq, " single commit"});
  endtask

  task automatic expect_drop(input string rq);
    int c0;
    c0 = ncommit;
    chk(mode_o, 0, {rq, " dropped mode"});
    chk(busy_o, 0, {rq, " dropped busy"});
    repeat (3) @(negedge clk);
    chk(ncommit, c0, {rq, " no commit"});
  endtask

  initial begin
    tot = 0; bad = 0; ncommit = 0;
    eprot = '0; esec = 1'b0;
    rst_n = 1'b0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    cfg_we = 0; cfg_prot = '0; cfg_secure = 0; op_fail = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk(mode_o, 0, "R11 reset mode");
    chk(busy_o, 0, "R11 reset busy");
    chk(stat_o, 8'h00, "R11 reset stat");
    chk(prot_pri_o, 8'h00, "R10 reset pri");
    chk(prot_sec_o, 8'h00, "R10 reset sec");
    chk(arr_commit_o, 0, "R3 reset commit");

    // Protection load and readback layout
    cfg(6'b100101, 1'b1, 1'b1);
    chk(prot_pri_o, 8'h05, "R9 pri layout");
    chk(prot_sec_o, 8'h82, "R9 sec layout");

    // Program to unprotected sector 1
    do_prog(15'h1234, 8'h5A);
    chk(mode_o, 2, "R1 program decoded");
    chk(stat_o, 8'h82, "R11 stat while programming");
    expect_op(2'd1, PC, 0, 15'h1234, 8'h5A, 6'b000010, "R3");

    // Protected and non-existent sectors
    do_prog(15'h0100, 8'h11);
    expect_drop("R4 protected sector0");
    do_prog(15'h7010, 8'h22);
    expect_drop("R4 sector7");
    do_erase(15'h2000, 8'h30);
    expect_drop("R4 erase protected sector2");

    // Reset ignored during program
    do_prog(15'h3111, 8'hC3);
    wr(15'h3000, 8'hF0);
    chk(mode_o, 2, "R5 reset ignored in program");
    expect_op(2'd1, PC, 1, 15'h3111, 8'hC3, 6'b001000, "R5");

    // Bulk erase with unlocked reset attempt during it
    do_erase(15'h0000, 8'h10);
    chk(mode_o, 4, "R12 bulk mode");
    unlock(); wr(15'h0555, 8'hF0);
    chk(mode_o, 4, "R5 reset ignored in bulk");
    expect_op(2'd3, BC, 3, 15'h0000, 8'h00, 6'b011010, "R12 bulk");

    // Sector erase aborted by reset
    begin
      int c0;
      c0 = ncommit;
      do_erase(15'h3abc, 8'h30);
      chk(mode_o, 3, "R6 sector erase mode");
      repeat (5) @(negedge clk);
      wr(15'h3000, 8'hF0);
      chk(mode_o, 6, "R6 abort recovery");
      chk(stat_o, 8'h86, "R11 stat in recovery");
      repeat (AC - 1) @(negedge clk);
      chk(busy_o, 1, "R6 busy through recovery");
      @(negedge clk);
      chk(mode_o, 0, "R6 back to read");
      @(negedge clk);
      chk(ncommit, c0, "R6 no commit after abort");
    end

    // Sector erase completing
    do_erase(15'h4abc, 8'h30);
    expect_op(2'd2, SC, 0, 15'h4abc, 8'h00, 6'b010000, "R12 sector erase");

    // Status mode
    unlock(); wr(15'h0555, 8'h90);
    chk(mode_o, 1, "R8 status entry");
    do_prog(15'h1000, 8'h77);
    chk(mode_o, 1, "R8 program ignored in status");
    chk(busy_o, 0, "R8 not busy in status");
    wr(15'h5000, 8'hF0);
    chk(mode_o, 0, "R8 bare reset leaves status");
    unlock(); wr(15'h0555, 8'h90);
    unlock(); wr(15'h0555, 8'hF0);
    chk(mode_o, 0, "R1 unlocked reset leaves status");

    // Error path
    begin
      int c0;
      c0 = ncommit;
      do_prog(15'h1010, 8'h99);
      @(negedge clk);
      op_fail = 1'b1;
      @(negedge clk);
      op_fail = 1'b0;
      chk(mode_o, 5, "R7 error mode");
      chk(stat_o, 8'h25, "R11 error stat bit5");
      do_prog(15'h1020, 8'h01);
      chk(mode_o, 5, "R7 program ignored in error");
      wr(15'h0000, 8'hF0);
      chk(mode_o, 6, "R7 reset starts recovery");
      repeat (EC - 1) @(negedge clk);
      chk(mode_o, 6, "R7 recovery length");
      @(negedge clk);
      chk(mode_o, 0, "R7 read after recovery");
      @(negedge clk);
      chk(ncommit, c0, "R7 no commit on error");
    end

    // Configuration ignored while busy
    do_prog(15'h1044, 8'h3C);
    cfg(6'b000000, 1'b0, 1'b0);
    chk(prot_pri_o, exp_pri(), "R10 cfg ignored pri");
    chk(prot_sec_o, exp_sec(), "R10 cfg ignored sec");
    expect_op(2'd1, PC, 1, 15'h1044, 8'h3C, 6'b000010, "R10 op");

    // Broken sequences
    wr(15'h0555, 8'hAA); wr(15'h0AAB, 8'h55); wr(15'h0555, 8'hA0); wr(15'h1000, 8'h33);
    expect_drop("R2 wrong unlock address");
    unlock(); wr(15'h0555, 8'h77); wr(15'h1000, 8'h33);
    expect_drop("R2 wrong command byte");
    do_erase(15'h1000, 8'h31);
    expect_drop("R2 wrong erase byte");

    // Bulk erase with everything protected
    cfg(6'h3F, 1'b0, 1'b1);
    do_erase(15'h1000, 8'h10);
    expect_drop("R4 bulk all protected");

    // Random program and sector erase against random protection
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      logic [7:0]    d;
      logic          er;
      cfg(6'($urandom), 1'($urandom), 1'b1);
      chk(prot_pri_o, exp_pri(), "R9 random pri");
      chk(prot_sec_o, exp_sec(), "R9 random sec");
      a  = AW'($urandom);
      d  = 8'($urandom);
      er = ($urandom % 4) == 0;
      if (er) do_erase(a, 8'h30);
      else    do_prog(a, d);
      if (is_prot(a)) expect_drop("R4 random");
      else if (er)    expect_op(2'd2, SC, 0, a, d, onehot(a), "R12 random");
      else            expect_op(2'd1, PC, 0, a, d, onehot(a), "R3 random");
    end

    // Random broken unlock attempts
    cfg(6'h00, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] bd, x;
      bd = 8'($urandom);
      if (bd == 8'h55) bd = 8'h56;
      x = 8'($urandom);
      if (x == 8'hAA) x = 8'hAB;
      wr(15'h0555, 8'hAA); wr(15'h0AAA, bd); wr(15'h0555, 8'hA0); wr(AW'($urandom), x);
      expect_drop("R2 random broken");
    end

    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tot++; bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

endmodule